// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts on its own slow, free-running clock, separate from the bus clock that software uses to reach it. Software sees four word locations: a key location, a divider-select location, a reload location and a status location. Distinct magic values written to the key location start the counter, refresh it from the reload value, or open the two configuration locations for writing. Once the counter has been started, software has no way to stop it. If the counter runs out without a refresh, the block raises a reset request for one slow-clock cycle.

The divider-select and reload values cross into the slow domain through a toggle handshake. While a crossing is in flight, a status bit reads as 1 and further writes to that location are dropped, so the value being carried stays stable. A debug-halt input, qualified by a debug-stop enable, freezes the count while the processor is held in debug.

Timing of one period, counted in slow-clock cycles from the start of counting or from the previous reset request, is (reload + 1) × divider.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the divider-select location (address 1, bits 2:0) reads 0, the reload location (address 2, bits 11:0) reads 0xFFF, the status location (address 3) reads 0, the key location (address 0) reads 0, and no reset request is raised while the counter has not been started.
- R2: A write of 0x5555 to the key location unlocks the divider-select and reload locations, and writes to them are then taken and read back.
- R3: Any key write other than 0x5555 locks the configuration again; a write to the divider-select or reload location while locked leaves the stored value unchanged.
- R4: A key write of 0xCCCC starts counting. A key write of 0xAAAA before the start does not start it. Once running, reset requests repeat every (reload + 1) × divider slow cycles.
- R5: Divider-select codes 0, 1, 2, 3 and 4 give dividers of 4, 8, 16, 32 and 64. Codes 5, 6 and 7 give a divider of 64.
- R6: A key write of 0xAAAA reloads the counter and restarts the divider. Refreshes that arrive more often than the timeout keep the reset request low.
- R7: Once started, no key write stops the counter; reset requests keep coming.
- R8: Status bit 0 is set by an accepted divider-select write, and status bit 1 by an accepted reload write. Each bit clears once its value has reached the slow domain. A write to a location whose status bit is set is ignored.
- R9: A reset request is high for exactly one slow-clock cycle.
- R10: While the debug-halt input and the debug-stop enable are both high, the count is frozen and no reset request occurs. With the enable low, a debug halt has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Write strobe, bus domain |
| wr_addr | input | 2 | Write location: 0 key, 1 divider select, 2 reload, 3 status |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read location |
| rd_data | output | 16 | Read data for rd_addr, combinational |
| lclk | input | 1 | Slow free-running counter clock |
| dbg_halt | input | 1 | Processor is halted in debug |
| dbg_stop_en | input | 1 | Allow a debug halt to freeze the count |
| rst_req | output | 1 | Reset request, one slow cycle wide, slow domain |

## Verification
The hardest case to reach is an exact period check after a configuration change. The new value only governs the counter after its crossing has finished, and the interval in progress at that moment mixes the old and new settings. The stimulus first waits for the status bit to clear, then lets one reset request go by, and only after that queues the expected interval. That interval is then measured from pulse to pulse in slow-clock cycles, which removes the handshake latency from the measurement. The freeze case uses the same approach. The bench lets the debug synchronizer settle before it starts counting pulses, and after releasing the freeze it confirms that pulses resume.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int RLW = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        lclk,
  input  logic        dbg_halt,
  input  logic        dbg_stop_en,
  output logic        rst_req
);
  localparam logic [15:0] KEY_OPEN  = 16'h5555;
  localparam logic [15:0] KEY_KICK  = 16'hAAAA;
  localparam logic [15:0] KEY_START = 16'hCCCC;
  localparam logic [1:0]  A_KEY = 2'd0, A_DIV = 2'd1, A_RLD = 2'd2, A_STAT = 2'd3;

  // bus domain
  logic           unlocked;
  logic [2:0]     div_q;
  logic [RLW-1:0] rld_q;
  logic           div_tgl, rld_tgl, kick_tgl, start_tgl;
  logic [1:0]     div_ack_sy, rld_ack_sy;
  logic           div_ack, rld_ack;

  wire key_wr   = wr_en && wr_addr == A_KEY;
  wire div_busy = div_tgl != div_ack_sy[1];
  wire rld_busy = rld_tgl != rld_ack_sy[1];
  wire div_wr   = wr_en && wr_addr == A_DIV && unlocked && !div_busy;
  wire rld_wr   = wr_en && wr_addr == A_RLD && unlocked && !rld_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unlocked   <= 1'b0;
      div_q      <= '0;
      rld_q      <= '1;
      div_tgl    <= 1'b0;
      rld_tgl    <= 1'b0;
      kick_tgl   <= 1'b0;
      start_tgl  <= 1'b0;
      div_ack_sy <= '0;
      rld_ack_sy <= '0;
    end else begin
      if (key_wr) begin
        unlocked <= wr_data == KEY_OPEN;
        if (wr_data == KEY_KICK)  kick_tgl  <= ~kick_tgl;
        if (wr_data == KEY_START) start_tgl <= ~start_tgl;
      end
      if (div_wr) begin
        div_q   <= wr_data[2:0];
        div_tgl <= ~div_tgl;
      end
      if (rld_wr) begin
        rld_q   <= wr_data[RLW-1:0];
        rld_tgl <= ~rld_tgl;
      end
      div_ack_sy <= {div_ack_sy[0], div_ack};
      rld_ack_sy <= {rld_ack_sy[0], rld_ack};
    end

  always_comb
    case (rd_addr)
      A_DIV:   rd_data = {13'd0, div_q};
      A_RLD:   rd_data = {{(16-RLW){1'b0}}, rld_q};
      A_STAT:  rd_data = {14'd0, rld_busy, div_busy};
      default: rd_data = 16'd0;
    endcase

  // slow domain
  logic [2:0]     div_sy, rld_sy, kick_sy, start_sy;
  logic [1:0]     frz_sy;
  logic [2:0]     div_s;
  logic [RLW-1:0] rld_s, cnt;
  logic [5:0]     pre;
  logic           running;

  wire div_e   = div_sy[2]   ^ div_sy[1];
  wire rld_e   = rld_sy[2]   ^ rld_sy[1];
  wire kick_e  = kick_sy[2]  ^ kick_sy[1];
  wire start_e = start_sy[2] ^ start_sy[1];
  wire freeze  = frz_sy[1];
  assign div_ack = div_sy[2];
  assign rld_ack = rld_sy[2];

  logic [5:0] pre_last;
  always_comb
    case (div_s)
      3'd0:    pre_last = 6'd3;
      3'd1:    pre_last = 6'd7;
      3'd2:    pre_last = 6'd15;
      3'd3:    pre_last = 6'd31;
      default: pre_last = 6'd63;
    endcase

  always_ff @(posedge lclk or negedge rst_n)
    if (!rst_n) begin
      div_sy   <= '0;
      rld_sy   <= '0;
      kick_sy  <= '0;
      start_sy <= '0;
      frz_sy   <= '0;
      div_s    <= '0;
      rld_s    <= '1;
      cnt      <= '1;
      pre      <= '0;
      running  <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      div_sy   <= {div_sy[1:0], div_tgl};
      rld_sy   <= {rld_sy[1:0], rld_tgl};
      kick_sy  <= {kick_sy[1:0], kick_tgl};
      start_sy <= {start_sy[1:0], start_tgl};
      frz_sy   <= {frz_sy[0], dbg_halt & dbg_stop_en};
      if (div_e) div_s <= div_q;
      if (rld_e) rld_s <= rld_q;
      if (start_e) running <= 1'b1;
      rst_req <= 1'b0;
      if (start_e || kick_e) begin
        cnt <= rld_s;
        pre <= '0;
      end else if (running && !freeze) begin
        if (pre >= pre_last) begin
          pre <= '0;
          if (cnt == '0) begin
            cnt     <= rld_s;
            rst_req <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    end

  // R3
  locked_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIV && !unlocked) |=> $stable(div_q));
  // R3
  locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RLD && !unlocked) |=> $stable(rld_q));
  // R8
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_wr |=> div_busy);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_RLD && rld_busy) |=> $stable(rld_q));
  // R7
  no_stop_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    running |=> running);
  // R4
  idle_quiet_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    !running |=> !rst_req);
  // R9
  one_cycle_req_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R10
  frozen_chk: assert property (@(posedge lclk) disable iff (!rst_n)
    (freeze && !start_e && !kick_e) |=> ($stable(cnt) && $stable(pre) && !rst_req));
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  logic clk = 0, lclk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] rd_data;
  logic dbg_halt = 0, dbg_stop_en = 0;
  logic rst_req;

  keyed_wdt uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .lclk(lclk),
    .dbg_halt(dbg_halt), .dbg_stop_en(dbg_stop_en), .rst_req(rst_req));

  always #5 clk = ~clk;
  always #40 lclk = ~lclk;

  int checks = 0, errors = 0;
  bit done = 0;
  int slow_cyc = 0, last_pulse = 0, pulse_cnt = 0;
  bit prev_req = 0;
  int exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: measures pulse spacing and width in slow cycles
  always @(negedge lclk) begin
    slow_cyc++;
    if (prev_req) chk(!rst_req, "R9 pulse width", int'(rst_req), 0);
    if (rst_req && !prev_req) begin
      int iv, e;
      string t;
      iv = slow_cyc - last_pulse;
      last_pulse = slow_cyc;
      pulse_cnt++;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(iv == e, t, iv, e);
      end
    end
    prev_req = rst_req;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic slow(input int n);
    repeat (n) @(negedge lclk);
  endtask

  task automatic settle(input string tag);
    logic [15:0] v;
    slow(20);
    rd(2'd3, v);
    chk(v == 16'd0, tag, v, 0);
  endtask

  // driver: lets one pulse pass, then queues the next interval
  task automatic expect_iv(input int e, input string tag);
    int n;
    n = pulse_cnt;
    wait (pulse_cnt > n);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    wait (exp_q.size() == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int m;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd(2'd1, v); chk(v == 16'd0,    "R1 divider reset", v, 0);
    rd(2'd2, v); chk(v == 16'hFFF,  "R1 reload reset", v, 16'hFFF);
    rd(2'd3, v); chk(v == 16'd0,    "R1 status reset", v, 0);
    rd(2'd0, v); chk(v == 16'd0,    "R1 key reads zero", v, 0);
    // R3 locked writes ignored
    wr(2'd1, 16'd3);  rd(2'd1, v); chk(v == 16'd0,   "R3 locked divider", v, 0);
    wr(2'd2, 16'd5);  rd(2'd2, v); chk(v == 16'hFFF, "R3 locked reload", v, 16'hFFF);
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234);
    wr(2'd1, 16'd2);  rd(2'd1, v); chk(v == 16'd0,   "R3 relock by other key", v, 0);
    // R2 unlock and configure, R8 busy flags
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'd0);
    rd(2'd3, v); chk(v[0] == 1'b1, "R8 divider busy set", v[0], 1);
    settle("R8 divider busy clear");
    wr(2'd2, 16'd3);
    rd(2'd3, v); chk(v[1] == 1'b1, "R8 reload busy set", v[1], 1);
    wr(2'd2, 16'd9);
    settle("R8 reload busy clear");
    rd(2'd2, v); chk(v == 16'd3, "R8 write while busy ignored", v, 3);
    wr(2'd1, 16'd4); settle("R8 busy clear");
    rd(2'd1, v); chk(v == 16'd4, "R2 divider readback", v, 4);
    wr(2'd1, 16'd0); settle("R8 busy clear");
    // R4 refresh before start does not start; R1 idle quiet
    wr(2'd0, 16'hAAAA);
    slow(60);
    chk(pulse_cnt == 0, "R4 no pulse before start", pulse_cnt, 0);
    // R4 start
    wr(2'd0, 16'hCCCC);
    expect_iv(16, "R4 period rl3 div4");
    expect_iv(16, "R4 period repeat");
    wr(2'd0, 16'h5555); wr(2'd2, 16'd10); settle("R8 busy clear");
    expect_iv(44, "R4 period rl10 div4");
    wr(2'd0, 16'h5555); wr(2'd2, 16'd3); settle("R8 busy clear");
    // R5 divider codes
    for (int c = 1; c < 8; c++) begin
      wr(2'd0, 16'h5555); wr(2'd1, 16'(c)); settle("R8 busy clear");
      expect_iv(4 * (c > 4 ? 64 : (4 << c)), $sformatf("R5 divider code %0d", c));
    end
    wr(2'd0, 16'h5555); wr(2'd1, 16'd0); settle("R8 busy clear");
    // R7 cannot stop
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234); wr(2'd0, 16'h0000); wr(2'd0, 16'hFFFF);
    expect_iv(16, "R7 still running after key writes");
    // R6 refresh prevents expiry
    m = pulse_cnt;
    wait (pulse_cnt > m);
    m = pulse_cnt;
    for (int i = 0; i < 30; i++) begin
      wr(2'd0, 16'hAAAA);
      slow(5);
    end
    chk(pulse_cnt == m, "R6 refresh holds off request", pulse_cnt - m, 0);
    expect_iv(16, "R6 period after refresh stops");
    // R10 debug freeze
    dbg_stop_en = 1; dbg_halt = 1;
    slow(10);
    m = pulse_cnt;
    slow(100);
    chk(pulse_cnt == m, "R10 frozen no request", pulse_cnt - m, 0);
    dbg_halt = 0;
    slow(40);
    chk(pulse_cnt > m, "R10 resumes after release", pulse_cnt - m, 1);
    dbg_stop_en = 0; dbg_halt = 1;
    slow(5);
    expect_iv(16, "R10 halt without enable counts");
    dbg_halt = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule